// File: doc/BRIEF.md
# Inter-Processor and Timer Interrupt Unit

This unit keeps two pending vectors of four bits each. One bit per CPU records an inter-processor interrupt (IPI) and drives that CPU's IPI line. A second bit per CPU records an interval-timer interrupt and drives that CPU's timer line. Only the lowest `NCPU` bits (1 to 4) are live. Bits above `NCPU` never set, and mask bits that target them are dropped.

Software reaches the unit through one 64-bit access port. Each access is a one-cycle strobe that carries a read/write flag, a 3-bit register select and the ID of the requesting CPU. A write to the shared control register (select 0) can do three things in one access: post IPIs, clear IPIs and clear timer interrupts. Each of these has its own CPU-mask field. Three dedicated registers post IPIs, clear IPIs or clear timer interrupts, using the mask in data bits 3:0. Two status registers read back the vectors. A tick input from an external timer posts the timer interrupt to every live CPU.

All state changes, warning pulses and read data are registered. They become visible in the cycle after the access or tick edge. Warning and error outputs are one-cycle pulses.

Top module: `ipi_tmr_irq_unit`

## Requirements
- R1: After reset, both pending vectors, all four flag outputs and `rd_valid` are zero.
- R2: A write to select 0 posts IPIs for the CPU mask in data bits 15:12 and clears IPIs for the mask in bits 11:8. When one write both posts and clears the same bit, the clear is applied last, so that bit ends up not pending.
- R3: A write to select 0 clears the timer-pending bits for the CPU mask in data bits 7:4.
- R4: A write to select 0 in which bits 15:4 are all zero and bit 28 is set is an acknowledge: it is accepted and changes nothing. If bit 28 is also clear, `err_unsupported` pulses. A write to select 4, 5, 6 or 7 also pulses `err_unsupported`. Neither case changes any state.
- R5: Posting an IPI to a CPU whose IPI is already pending pulses `warn_dup_post` and leaves that bit set.
- R6: Clearing an IPI for a CPU whose bit is neither pending nor posted by the same write pulses `warn_spur_clr`.
- R7: Writes to select 1, 2 and 3 use the mask in data bits 3:0. Select 1 posts IPIs, select 2 clears IPIs and select 3 clears timer bits.
- R8: A write to select 1, 2 or 3 whose mask is zero after the live-CPU filter pulses `err_zero_mask` and changes nothing.
- R9: A tick sets the timer bit of every live CPU. If a timer clear arrives in the same cycle as a tick, the tick takes priority.
- R10: Mask bits at or above `NCPU` are ignored. `ipi_irq` and `tmr_irq` bits at or above `NCPU` stay zero.
- R11: A read returns `rd_valid` high with `rd_data` in the next cycle. Select 0 returns the IPI vector in bits 11:8, the timer vector in bits 7:4 and the requesting CPU ID in bits 1:0, with all other bits zero. Select 4 returns the IPI vector in bits 3:0 and select 5 returns the timer vector in bits 3:0. Any other select reads as zero. `rd_valid` is low in every cycle that does not follow a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_en | input | 1 | Access strobe, one cycle per access |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_sel | input | 3 | Register select |
| acc_wdata | input | 64 | Write data |
| acc_cpu | input | 2 | ID of the CPU making the access |
| tick | input | 1 | Periodic timer tick |
| ipi_irq | output | 4 | IPI pending per CPU |
| tmr_irq | output | 4 | Timer interrupt pending per CPU |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 64 | Read data |
| warn_dup_post | output | 1 | Pulse: IPI posted to a CPU already pending |
| warn_spur_clr | output | 1 | Pulse: IPI cleared for a CPU not pending |
| err_zero_mask | output | 1 | Pulse: dedicated register written with an empty mask |
| err_unsupported | output | 1 | Pulse: write that nothing decodes |

## Verification
The bench targets the cases where ordering matters. The first is a post and a clear of the same bit in one control write; a design that applies the clear before the post would leave that bit pending. The second is a tick that lands together with a timer clear; a design that lets the clear win would drop a tick. The bench also posts to a pending CPU and clears a CPU that is not pending, and checks that each raises its pulse without changing state. It writes masks that name only CPUs above `NCPU`; here the dedicated registers must report an empty mask, and the control register must stay silent. Finally it checks that an acknowledge-only write is not flagged, so a decoder that tests only the mask fields would be caught.

// File: rtl/ipi_tmr_pkg.sv
package ipi_tmr_pkg;

    localparam int VEC_W  = 4;
    localparam int DATA_W = 64;
    localparam int SEL_W  = 3;

    // Bit positions inside a control-register write
    localparam int CTL_POST_LSB = 12;
    localparam int CTL_CLR_LSB  = 8;
    localparam int CTL_TCLR_LSB = 4;
    localparam int CTL_ACK_BIT  = 28;

    // Positions inside a control-register read
    localparam int RD_IPI_LSB = 8;
    localparam int RD_TMR_LSB = 4;

    typedef enum logic [SEL_W-1:0] {
        SEL_CTRL     = 3'd0,
        SEL_IPI_POST = 3'd1,
        SEL_IPI_CLR  = 3'd2,
        SEL_TMR_CLR  = 3'd3,
        SEL_IPI_STAT = 3'd4,
        SEL_TMR_STAT = 3'd5
    } reg_sel_e;

    typedef struct packed {
        logic [VEC_W-1:0] ipi_post;
        logic [VEC_W-1:0] ipi_clr;
        logic [VEC_W-1:0] tmr_clr;
        logic             zero_mask;
        logic             unsupported;
    } wr_cmd_t;

endpackage

// File: rtl/ipi_cmd_decode.sv
module ipi_cmd_decode
    import ipi_tmr_pkg::*;
#(
    parameter int NCPU = 4
) (
    input  logic              acc_en,
    input  logic              acc_wr,
    input  logic [SEL_W-1:0]  acc_sel,
    input  logic [DATA_W-1:0] acc_wdata,
    output wr_cmd_t           cmd
);
    localparam logic [VEC_W-1:0] LIVE = VEC_W'((1 << NCPU) - 1);

    logic [VEC_W-1:0] low_mask;
    logic             ctl_fields_used;

    assign low_mask        = acc_wdata[VEC_W-1:0] & LIVE;
    assign ctl_fields_used = (|acc_wdata[CTL_POST_LSB+VEC_W-1:CTL_TCLR_LSB])
                           | acc_wdata[CTL_ACK_BIT];

    always_comb begin
        cmd = '0;
        if (acc_en && acc_wr) begin
            case (reg_sel_e'(acc_sel))
                SEL_CTRL: begin
                    cmd.ipi_post    = acc_wdata[CTL_POST_LSB +: VEC_W] & LIVE;
                    cmd.ipi_clr     = acc_wdata[CTL_CLR_LSB  +: VEC_W] & LIVE;
                    cmd.tmr_clr     = acc_wdata[CTL_TCLR_LSB +: VEC_W] & LIVE;
                    cmd.unsupported = !ctl_fields_used;
                end
                SEL_IPI_POST: begin
                    cmd.ipi_post  = low_mask;
                    cmd.zero_mask = (low_mask == '0);
                end
                SEL_IPI_CLR: begin
                    cmd.ipi_clr   = low_mask;
                    cmd.zero_mask = (low_mask == '0);
                end
                SEL_TMR_CLR: begin
                    cmd.tmr_clr   = low_mask;
                    cmd.zero_mask = (low_mask == '0);
                end
                default: cmd.unsupported = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/ipi_pend_vec.sv
module ipi_pend_vec
    import ipi_tmr_pkg::*;
#(
    parameter int NCPU       = 4,
    parameter bit CLEAR_LAST = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VEC_W-1:0] set_v,
    input  logic [VEC_W-1:0] clr_v,
    output logic [VEC_W-1:0] pend
);
    localparam logic [VEC_W-1:0] LIVE = VEC_W'((1 << NCPU) - 1);

    logic [VEC_W-1:0] nxt;

    generate
        if (CLEAR_LAST) begin : g_clear_last
            assign nxt = (pend | set_v) & ~clr_v;
        end else begin : g_set_last
            assign nxt = (pend & ~clr_v) | set_v;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend <= '0;
        else        pend <= nxt & LIVE;
    end
endmodule

// File: rtl/ipi_tmr_irq_unit.sv
module ipi_tmr_irq_unit
    import ipi_tmr_pkg::*;
#(
    parameter int NCPU = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_en,
    input  logic              acc_wr,
    input  logic [2:0]        acc_sel,
    input  logic [63:0]       acc_wdata,
    input  logic [1:0]        acc_cpu,
    input  logic              tick,
    output logic [3:0]        ipi_irq,
    output logic [3:0]        tmr_irq,
    output logic              rd_valid,
    output logic [63:0]       rd_data,
    output logic              warn_dup_post,
    output logic              warn_spur_clr,
    output logic              err_zero_mask,
    output logic              err_unsupported
);
    localparam logic [VEC_W-1:0] LIVE = VEC_W'((1 << NCPU) - 1);

    wr_cmd_t          cmd;
    logic [VEC_W-1:0] ipi_post_v;
    logic [VEC_W-1:0] ipi_clr_v;
    logic [VEC_W-1:0] tick_v;
    logic             dup_hit;
    logic             spur_hit;
    logic             rd_req;
    logic [DATA_W-1:0] rd_mux;

    ipi_cmd_decode #(.NCPU(NCPU)) u_dec (
        .acc_en    (acc_en),
        .acc_wr    (acc_wr),
        .acc_sel   (acc_sel),
        .acc_wdata (acc_wdata),
        .cmd       (cmd)
    );

    assign ipi_post_v = cmd.ipi_post;
    assign ipi_clr_v  = cmd.ipi_clr;
    assign tick_v     = tick ? LIVE : '0;

    // IPI: a post and a clear of one bit in one write ends cleared
    ipi_pend_vec #(.NCPU(NCPU), .CLEAR_LAST(1'b1)) u_ipi (
        .clk   (clk),
        .rst_n (rst_n),
        .set_v (ipi_post_v),
        .clr_v (ipi_clr_v),
        .pend  (ipi_irq)
    );

    // Timer: a tick beats a same-cycle clear
    ipi_pend_vec #(.NCPU(NCPU), .CLEAR_LAST(1'b0)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .set_v (tick_v),
        .clr_v (cmd.tmr_clr),
        .pend  (tmr_irq)
    );

    assign dup_hit  = |(ipi_post_v & ipi_irq);
    assign spur_hit = |(ipi_clr_v & ~(ipi_irq | ipi_post_v));
    assign rd_req   = acc_en && !acc_wr;

    always_comb begin
        rd_mux = '0;
        case (reg_sel_e'(acc_sel))
            SEL_CTRL: begin
                rd_mux[RD_IPI_LSB +: VEC_W] = ipi_irq;
                rd_mux[RD_TMR_LSB +: VEC_W] = tmr_irq;
                rd_mux[1:0]                 = acc_cpu;
            end
            SEL_IPI_STAT: rd_mux[VEC_W-1:0] = ipi_irq;
            SEL_TMR_STAT: rd_mux[VEC_W-1:0] = tmr_irq;
            default:      rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            warn_dup_post   <= 1'b0;
            warn_spur_clr   <= 1'b0;
            err_zero_mask   <= 1'b0;
            err_unsupported <= 1'b0;
            rd_valid        <= 1'b0;
            rd_data         <= '0;
        end else begin
            warn_dup_post   <= dup_hit;
            warn_spur_clr   <= spur_hit;
            err_zero_mask   <= cmd.zero_mask;
            err_unsupported <= cmd.unsupported;
            rd_valid        <= rd_req;
            rd_data         <= rd_req ? rd_mux : '0;
        end
    end
endmodule

// File: rtl/ipi_tmr_irq_chk.sv
module ipi_tmr_irq_chk #(
    parameter int NCPU = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       acc_en,
    input logic       acc_wr,
    input logic       tick,
    input logic [3:0] post_v,
    input logic [3:0] clr_v,
    input logic [3:0] ipi_irq,
    input logic [3:0] tmr_irq,
    input logic       rd_valid
);
    localparam logic [3:0] LIVE = 4'((1 << NCPU) - 1);

    AST_POST_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (|(post_v & ~clr_v)) |=> ((ipi_irq & $past(post_v & ~clr_v)) == $past(post_v & ~clr_v))); // R2
    AST_CLEAR_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_v) |=> ((ipi_irq & $past(clr_v)) == 4'b0)); // R2
    AST_TICK_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (tmr_irq == LIVE)); // R9
    AST_DEAD_CPUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((ipi_irq | tmr_irq) & ~LIVE) == 4'b0); // R10
    AST_READ_ANSWERS: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !acc_wr) |=> rd_valid); // R11
    AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_en && !acc_wr) |=> !rd_valid); // R11
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_en && !tick) |=> ($stable(ipi_irq) && $stable(tmr_irq))); // R4
endmodule

bind ipi_tmr_irq_unit ipi_tmr_irq_chk #(.NCPU(NCPU)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_en   (acc_en),
    .acc_wr   (acc_wr),
    .tick     (tick),
    .post_v   (ipi_post_v),
    .clr_v    (ipi_clr_v),
    .ipi_irq  (ipi_irq),
    .tmr_irq  (tmr_irq),
    .rd_valid (rd_valid)
);

// File: tb/ipi_tmr_irq_unit_tb.sv
module ipi_tmr_irq_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NCPU = 3;
    localparam logic [3:0] LIVE = 4'((1 << NCPU) - 1);

    typedef struct {
        logic [3:0]  ipi;
        logic [3:0]  tmr;
        logic        dup;
        logic        spur;
        logic        zero;
        logic        uns;
        logic        rv;
        logic [63:0] rdata;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_en = 1'b0;
    logic        acc_wr = 1'b0;
    logic [2:0]  acc_sel = '0;
    logic [63:0] acc_wdata = '0;
    logic [1:0]  acc_cpu = '0;
    logic        tick = 1'b0;
    logic [3:0]  ipi_irq, tmr_irq;
    logic        rd_valid, warn_dup_post, warn_spur_clr, err_zero_mask, err_unsupported;
    logic [63:0] rd_data;

    exp_t exp_q[$];
    logic [3:0] m_ipi = '0;
    logic [3:0] m_tmr = '0;
    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ipi_tmr_irq_unit #(.NCPU(NCPU)) u_dut (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
        .acc_sel(acc_sel), .acc_wdata(acc_wdata), .acc_cpu(acc_cpu), .tick(tick),
        .ipi_irq(ipi_irq), .tmr_irq(tmr_irq), .rd_valid(rd_valid), .rd_data(rd_data),
        .warn_dup_post(warn_dup_post), .warn_spur_clr(warn_spur_clr),
        .err_zero_mask(err_zero_mask), .err_unsupported(err_unsupported)
    );

    task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Driver: applies one cycle of stimulus and queues the expected result
    task automatic drive(bit en, bit wr, logic [2:0] sel, logic [63:0] d,
                         logic [1:0] cpu, bit tk, string tag);
        exp_t e;
        logic [3:0] post, clr, tclr;
        post = '0; clr = '0; tclr = '0;
        @(negedge clk);
        acc_en = en; acc_wr = wr; acc_sel = sel; acc_wdata = d; acc_cpu = cpu; tick = tk;
        e.dup = 0; e.spur = 0; e.zero = 0; e.uns = 0; e.rv = 0; e.rdata = '0; e.tag = tag;
        if (en && wr) begin
            case (sel)
                3'd0: begin
                    post = d[15:12] & LIVE; clr = d[11:8] & LIVE; tclr = d[7:4] & LIVE;
                    e.uns = (d[15:4] == '0) && !d[28];
                end
                3'd1: begin post = d[3:0] & LIVE; e.zero = (post == '0); end
                3'd2: begin clr  = d[3:0] & LIVE; e.zero = (clr == '0); end
                3'd3: begin tclr = d[3:0] & LIVE; e.zero = (tclr == '0); end
                default: e.uns = 1;
            endcase
        end
        if (en && !wr) begin
            e.rv = 1;
            case (sel)
                3'd0: e.rdata = {52'd0, m_ipi, m_tmr, 2'b00, cpu};
                3'd4: e.rdata = {60'd0, m_ipi};
                3'd5: e.rdata = {60'd0, m_tmr};
                default: e.rdata = '0;
            endcase
        end
        e.dup  = |(post & m_ipi);
        e.spur = |(clr & ~(m_ipi | post));
        m_ipi = (m_ipi | post) & ~clr;
        m_tmr = (m_tmr & ~tclr) | (tk ? LIVE : 4'b0);
        e.ipi = m_ipi; e.tmr = m_tmr;
        exp_q.push_back(e);
    endtask

    task automatic idle(string tag);
        drive(0, 0, 3'd0, 64'd0, 2'd0, 0, tag);
    endtask

    task automatic wr(logic [2:0] sel, logic [63:0] d, string tag);
        drive(1, 1, sel, d, 2'd0, 0, tag);
    endtask

    // Monitor: compares one queued item per clock, just after the edge
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check(e.tag, "ipi_irq", 64'(ipi_irq), 64'(e.ipi));
            check(e.tag, "tmr_irq", 64'(tmr_irq), 64'(e.tmr));
            check(e.tag, "warn_dup_post", 64'(warn_dup_post), 64'(e.dup));
            check(e.tag, "warn_spur_clr", 64'(warn_spur_clr), 64'(e.spur));
            check(e.tag, "err_zero_mask", 64'(err_zero_mask), 64'(e.zero));
            check(e.tag, "err_unsupported", 64'(err_unsupported), 64'(e.uns));
            check(e.tag, "rd_valid", 64'(rd_valid), 64'(e.rv));
            if (e.rv) check(e.tag, "rd_data", rd_data, e.rdata);
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle("R1 reset state");
        wr(3'd0, 64'h3000, "R2 control post 0011");
        wr(3'd0, 64'h1000, "R5 post to pending cpu0");
        wr(3'd0, 64'h0400, "R6 clear of idle cpu2");
        drive(0, 0, 3'd0, 64'd0, 2'd0, 1, "R9 tick fills live cpus");
        wr(3'd0, 64'h0020, "R3 control timer clear cpu1");
        drive(1, 0, 3'd0, 64'd0, 2'd2, 0, "R11 control read cpu2");
        wr(3'd0, 64'h4400, "R2 post and clear same bit");
        wr(3'd0, 64'h4110, "R2 R3 combined fields");
        wr(3'd0, 64'h1000_0000, "R4 acknowledge only");
        wr(3'd0, 64'h0, "R4 empty control write");
        wr(3'd1, 64'h8, "R8 R10 post mask only dead cpu");
        wr(3'd1, 64'hFFFF_0000_0000_0009, "R7 R10 dedicated post");
        wr(3'd2, 64'h2, "R7 dedicated ipi clear");
        wr(3'd3, 64'h4, "R7 dedicated timer clear");
        wr(3'd2, 64'h0, "R8 zero clear mask");
        wr(3'd3, 64'h0, "R8 zero timer mask");
        drive(1, 1, 3'd3, 64'h7, 2'd0, 1, "R9 tick beats timer clear");
        wr(3'd0, 64'h8000, "R10 control post dead cpu");
        drive(1, 0, 3'd4, 64'd0, 2'd1, 0, "R11 ipi status read");
        drive(1, 0, 3'd5, 64'd0, 2'd1, 0, "R11 timer status read");
        drive(1, 0, 3'd6, 64'd0, 2'd3, 0, "R11 undefined select read");
        drive(1, 0, 3'd0, 64'd0, 2'd3, 0, "R11 control read cpu3");
        wr(3'd6, 64'h7, "R4 write undefined select");
        wr(3'd4, 64'h7, "R4 write status select");
        wr(3'd0, 64'h0700, "R2 clear all ipi");
        wr(3'd0, 64'h0070, "R3 clear all timer");
        idle("R1 idle hold");
        idle("R11 no valid after idle");
        while (exp_q.size() > 0) @(posedge clk);
        #2;
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule